// File: doc/BRIEF.md
# Direct-Monitoring Routing Mixer

This block mixes live input samples straight onto a pair of monitor outputs, so that a performer hears the inputs without the signal passing through a host. Each input has two 32-bit routing words, a left word and a right word, written through a simple register-write port. The pair of words selects one of four routes for that input: silent, output 1 only, output 2 only, or centred across both outputs.

Samples for every input arrive together on one wide bus, qualified by a one-cycle strobe. On each strobe the block adds every routed input into two wide accumulators. A centred input enters each output at half level. Each sum is then clipped to the signed 24-bit range and registered. The two outputs are held until the next strobe.

The register window has eighteen inputs at an 8-byte stride. Analog inputs 1 to 8 come first, then the two coaxial digital inputs, then the eight optical inputs. Word values the block does not recognise, and pairs that are not one of the four valid combinations, leave the input silent.

Top module: `mon_mix_top`

## Requirements
- R1: After reset, mix_out1, mix_out2 and mix_valid are 0, and every input's routing is silent, so a strobe before any register write yields 0 on both outputs.
- R2: A write to BASE_ADDR + 8*i sets the left word of input i, and a write to BASE_ADDR + 8*i + 4 sets its right word. Input indices 0 to 7 are analog 1 to 8, indices 8 and 9 are coaxial digital 1 and 2, and indices 10 to 17 are optical 1 to 8. Input i occupies bits [24*i+23 : 24*i] of smp_bus.
- R3: A left word of 0x20000000 with a right word of 0x00000000 adds the input's full sample to mix_out1 only.
- R4: A left word of 0x00000000 with a right word of 0x20000000 adds the input's full sample to mix_out2 only.
- R5: Left and right words both 0x18000000 add the sample, arithmetically shifted right by one bit, to both outputs.
- R6: Any other pair of words leaves the input silent. This includes both words at 0x20000000, a lone 0x18000000, and any unrecognised value.
- R7: Writes whose address lies below BASE_ADDR, at or beyond BASE_ADDR + 8*NUM_IN, or that are not 4-byte aligned change no routing.
- R8: Each output is the sum of all its contributions, saturated to the range -8388608 to +8388607.
- R9: The outputs take their new values at the first clock edge after a strobe, and mix_valid is high for exactly that one cycle. Without a strobe, the outputs hold their values even when smp_bus changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 32 | Register byte address |
| wr_data | input | 32 | Routing word to write |
| smp_valid | input | 1 | Sample strobe |
| smp_bus | input | 432 | All input samples, signed 24 bits each |
| mix_out1 | output | 24 | Monitor output 1, signed |
| mix_out2 | output | 24 | Monitor output 2, signed |
| mix_valid | output | 1 | High for one cycle when new outputs are available |

## Verification
The bench builds the block with its default parameters: eighteen inputs, 24-bit samples and the default base address. This makes the last slot (offset 0x8C) and the first address past the window (offset 0x90) both reachable. With 24-bit samples, three full-scale inputs on one output are enough to drive the accumulator past both saturation limits. The bench also places the two identical-looking halves of a centred pair on odd negative samples, which exposes any rounding that differs from an arithmetic shift.

// File: rtl/mon_mix_pkg.sv
package mon_mix_pkg;

    typedef enum logic [1:0] {
        ROUTE_OFF    = 2'd0,
        ROUTE_OUT1   = 2'd1,
        ROUTE_OUT2   = 2'd2,
        ROUTE_CENTRE = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        WORD_NONE   = 2'd0,
        WORD_STEREO = 2'd1,
        WORD_SINGLE = 2'd2,
        WORD_OTHER  = 2'd3
    } word_e;

    localparam logic [31:0] WVAL_NONE   = 32'h0000_0000;
    localparam logic [31:0] WVAL_STEREO = 32'h1800_0000;
    localparam logic [31:0] WVAL_SINGLE = 32'h2000_0000;

    function automatic word_e classify_word(input logic [31:0] w);
        if (w == WVAL_NONE)        return WORD_NONE;
        else if (w == WVAL_STEREO) return WORD_STEREO;
        else if (w == WVAL_SINGLE) return WORD_SINGLE;
        else                       return WORD_OTHER;
    endfunction

    function automatic route_e pair_to_route(input word_e l, input word_e r);
        if (l == WORD_SINGLE && r == WORD_NONE)        return ROUTE_OUT1;
        else if (l == WORD_NONE && r == WORD_SINGLE)   return ROUTE_OUT2;
        else if (l == WORD_STEREO && r == WORD_STEREO) return ROUTE_CENTRE;
        else                                           return ROUTE_OFF;
    endfunction

endpackage

// File: rtl/mon_route_regs.sv
module mon_route_regs
    import mon_mix_pkg::*;
#(
    parameter int          NUM_IN    = 18,
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'hE000_0300
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    output logic [2*NUM_IN-1:0] route
);

    localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_IN * 8);

    logic [ADDR_W-1:0] offset;
    logic              hit;
    logic [IDX_W-1:0]  slot;
    logic              right_side;
    word_e             wcode;

    always_comb begin
        offset     = wr_addr - BASE;
        hit        = wr_en && (wr_addr >= BASE) && (offset < SPAN) && (offset[1:0] == 2'b00);
        slot       = offset[IDX_W+2:3];
        right_side = offset[2];
        wcode      = classify_word(wr_data);
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
        word_e left_q;
        word_e right_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                left_q  <= WORD_NONE;
                right_q <= WORD_NONE;
            end else if (hit && slot == IDX_W'(i)) begin
                if (right_side) right_q <= wcode;
                else            left_q  <= wcode;
            end
        end

        assign route[2*i +: 2] = pair_to_route(left_q, right_q);
    end

endmodule

// File: rtl/mon_sum_sat.sv
module mon_sum_sat
    import mon_mix_pkg::*;
#(
    parameter int NUM_IN = 18,
    parameter int SW     = 24,
    parameter int ACC_W  = SW + 6
) (
    input  logic [NUM_IN*SW-1:0] smp_bus,
    input  logic [2*NUM_IN-1:0]  route,
    output logic [SW-1:0]        mix1,
    output logic [SW-1:0]        mix2
);

    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (SW-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    function automatic logic [SW-1:0] clip(input logic signed [ACC_W-1:0] a);
        if (a > MAXV)      return MAXV[SW-1:0];
        else if (a < MINV) return MINV[SW-1:0];
        else               return a[SW-1:0];
    endfunction

    logic signed [ACC_W-1:0] acc1;
    logic signed [ACC_W-1:0] acc2;
    logic        [SW-1:0]    smp;
    logic signed [ACC_W-1:0] full;
    logic signed [ACC_W-1:0] half;

    always_comb begin
        acc1 = '0;
        acc2 = '0;
        smp  = '0;
        full = '0;
        half = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            smp  = smp_bus[i*SW +: SW];
            full = {{(ACC_W-SW){smp[SW-1]}}, smp};
            half = full >>> 1;
            unique case (route_e'(route[2*i +: 2]))
                ROUTE_OFF:    ;
                ROUTE_OUT1:   acc1 = acc1 + full;
                ROUTE_OUT2:   acc2 = acc2 + full;
                ROUTE_CENTRE: begin
                    acc1 = acc1 + half;
                    acc2 = acc2 + half;
                end
            endcase
        end
        mix1 = clip(acc1);
        mix2 = clip(acc2);
    end

endmodule

// File: rtl/mon_mix_top.sv
module mon_mix_top
    import mon_mix_pkg::*;
#(
    parameter int          NUM_IN    = 18,
    parameter int          SAMPLE_W  = 24,
    parameter logic [31:0] BASE_ADDR = 32'hE000_0300
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [31:0]                  wr_addr,
    input  logic [31:0]                  wr_data,
    input  logic                         smp_valid,
    input  logic [NUM_IN*SAMPLE_W-1:0]   smp_bus,
    output logic [SAMPLE_W-1:0]          mix_out1,
    output logic [SAMPLE_W-1:0]          mix_out2,
    output logic                         mix_valid
);

    localparam int ACC_W = SAMPLE_W + $clog2(NUM_IN + 1) + 1;

    logic [2*NUM_IN-1:0]  route_w;
    logic [SAMPLE_W-1:0]  sum1_w;
    logic [SAMPLE_W-1:0]  sum2_w;

    mon_route_regs #(
        .NUM_IN    (NUM_IN),
        .ADDR_W    (32),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .route   (route_w)
    );

    mon_sum_sat #(
        .NUM_IN (NUM_IN),
        .SW     (SAMPLE_W),
        .ACC_W  (ACC_W)
    ) u_sum (
        .smp_bus (smp_bus),
        .route   (route_w),
        .mix1    (sum1_w),
        .mix2    (sum2_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mix_out1  <= '0;
            mix_out2  <= '0;
            mix_valid <= 1'b0;
        end else begin
            mix_valid <= smp_valid;
            if (smp_valid) begin
                mix_out1 <= sum1_w;
                mix_out2 <= sum2_w;
            end
        end
    end

endmodule

// File: rtl/mon_mix_chk.sv
module mon_mix_chk #(
    parameter int          NUM_IN    = 18,
    parameter int          SW        = 24,
    parameter logic [31:0] BASE_ADDR = 32'hE000_0300
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [31:0]         wr_addr,
    input logic                smp_valid,
    input logic [SW-1:0]       mix_out1,
    input logic [SW-1:0]       mix_out2,
    input logic                mix_valid,
    input logic [2*NUM_IN-1:0] route
);

    localparam logic [31:0] LIMIT = BASE_ADDR + 32'(NUM_IN * 8);

    logic stray_write;
    assign stray_write = wr_en && ((wr_addr < BASE_ADDR) || (wr_addr >= LIMIT) || (wr_addr[1:0] != 2'b00));

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> mix_valid);

    assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !mix_valid);

    assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(mix_out1) && $stable(mix_out2)));

    assert_silent_when_unrouted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && route == '0) |=> (mix_out1 == '0 && mix_out2 == '0));

    assert_stray_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stray_write |=> $stable(route));

endmodule

bind mon_mix_top mon_mix_chk #(
    .NUM_IN    (NUM_IN),
    .SW        (SAMPLE_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .smp_valid (smp_valid),
    .mix_out1  (mix_out1),
    .mix_out2  (mix_out2),
    .mix_valid (mix_valid),
    .route     (route_w)
);

// File: tb/mon_mix_top_tb.sv
`timescale 1ns/1ps
module mon_mix_top_tb;

    localparam int          N    = 18;
    localparam int          W    = 24;
    localparam logic [31:0] BASE = 32'hE000_0300;
    localparam logic [31:0] NONE = 32'h0000_0000;
    localparam logic [31:0] STER = 32'h1800_0000;
    localparam logic [31:0] ONE  = 32'h2000_0000;
    localparam int          NV   = 8;

    // {channel[8], left[32], right[32], sample[24], exp1[24], exp2[24]}
    localparam logic [143:0] VEC [NV] = '{
        {8'd0,  ONE,  NONE, 24'h000064, 24'h000064, 24'h000000},
        {8'd3,  NONE, ONE,  24'hFFFF06, 24'h000000, 24'hFFFF06},
        {8'd9,  STER, STER, 24'h0003E9, 24'h0001F4, 24'h0001F4},
        {8'd17, STER, STER, 24'hFFFFF9, 24'hFFFFFC, 24'hFFFFFC},
        {8'd10, ONE,  ONE,  24'h001000, 24'h000000, 24'h000000},
        {8'd5,  STER, NONE, 24'h001000, 24'h000000, 24'h000000},
        {8'd12, 32'h12345678, NONE, 24'h001000, 24'h000000, 24'h000000},
        {8'd8,  NONE, ONE,  24'h7FFFFF, 24'h000000, 24'h7FFFFF}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [31:0]        wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               smp_valid = 1'b0;
    logic [N*W-1:0]     smp_bus = '0;
    logic [W-1:0]       mix_out1;
    logic [W-1:0]       mix_out2;
    logic               mix_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mon_mix_top #(.NUM_IN(N), .SAMPLE_W(W), .BASE_ADDR(BASE)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .smp_valid (smp_valid),
        .smp_bus   (smp_bus),
        .mix_out1  (mix_out1),
        .mix_out2  (mix_out2),
        .mix_valid (mix_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] a, input logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic clear_all();
        for (int c = 0; c < N; c++) begin
            reg_write(BASE + 32'(8*c), NONE);
            reg_write(BASE + 32'(8*c + 4), NONE);
        end
    endtask

    task automatic fill_noise();
        for (int c = 0; c < N; c++) smp_bus[c*W +: W] = 24'(32'h1234 + c);
    endtask

    task automatic strobe();
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ch;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 out1 in reset", 32'(mix_out1), 0);
        check("R1 out2 in reset", 32'(mix_out2), 0);
        check("R1 valid in reset", 32'(mix_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        fill_noise();
        strobe();
        check("R1 out1 silent after reset", 32'(mix_out1), 0);
        check("R1 out2 silent after reset", 32'(mix_out2), 0);

        // Table walk: R3 R4 R5 R6 R2
        for (int v = 0; v < NV; v++) begin
            clear_all();
            ch = VEC[v][143:136];
            reg_write(BASE + 32'(8*ch), VEC[v][135:104]);
            reg_write(BASE + 32'(8*ch + 4), VEC[v][103:72]);
            fill_noise();
            smp_bus[ch*W +: W] = VEC[v][71:48];
            strobe();
            check($sformatf("R3/R4/R5/R6 vec%0d out1", v), 32'(mix_out1), 32'(VEC[v][47:24]));
            check($sformatf("R3/R4/R5/R6 vec%0d out2", v), 32'(mix_out2), 32'(VEC[v][23:0]));
        end

        // R2: last slot right word at offset 0x8C
        clear_all();
        reg_write(BASE + 32'h8C, ONE);
        fill_noise();
        smp_bus[17*W +: W] = 24'h000777;
        strobe();
        check("R2 last slot out2", 32'(mix_out2), 32'h777);
        check("R2 last slot out1", 32'(mix_out1), 0);

        // R7: stray writes ignored
        clear_all();
        reg_write(BASE - 32'd8, ONE);
        reg_write(BASE + 32'h90, ONE);
        reg_write(BASE + 32'h01, ONE);
        reg_write(BASE + 32'h06, ONE);
        fill_noise();
        strobe();
        check("R7 out1 after stray writes", 32'(mix_out1), 0);
        check("R7 out2 after stray writes", 32'(mix_out2), 0);

        // R8: mixed sum without saturation (also R3, R5)
        clear_all();
        reg_write(BASE + 32'd0, ONE);
        reg_write(BASE + 32'd8, ONE);
        reg_write(BASE + 32'd16, STER);
        reg_write(BASE + 32'd20, STER);
        fill_noise();
        smp_bus[0*W +: W] = 24'd10;
        smp_bus[1*W +: W] = 24'd20;
        smp_bus[2*W +: W] = 24'd40;
        strobe();
        check("R8 sum out1", 32'(mix_out1), 32'd50);
        check("R8 sum out2", 32'(mix_out2), 32'd20);

        // R8: positive and negative saturation
        clear_all();
        for (int c = 0; c < 3; c++) reg_write(BASE + 32'(8*c), ONE);
        for (int c = 3; c < 6; c++) reg_write(BASE + 32'(8*c + 4), ONE);
        fill_noise();
        for (int c = 0; c < 3; c++) smp_bus[c*W +: W] = 24'h7FFFFF;
        for (int c = 3; c < 6; c++) smp_bus[c*W +: W] = 24'h800000;
        strobe();
        check("R8 positive clip", 32'(mix_out1), 32'h7FFFFF);
        check("R8 negative clip", 32'(mix_out2), 32'h800000);

        // R8: clip on out1 while centred half stays on out2
        clear_all();
        reg_write(BASE + 32'd0, ONE);
        reg_write(BASE + 32'd8, STER);
        reg_write(BASE + 32'd12, STER);
        fill_noise();
        smp_bus[0*W +: W] = 24'h7FFFFF;
        smp_bus[1*W +: W] = 24'h7FFFFF;
        strobe();
        check("R8 clip with centre out1", 32'(mix_out1), 32'h7FFFFF);
        check("R8 centre half out2", 32'(mix_out2), 32'h3FFFFF);

        // R9: timing and hold
        clear_all();
        reg_write(BASE + 32'd0, ONE);
        fill_noise();
        smp_bus[0*W +: W] = 24'd300;
        smp_valid = 1'b1;
        check("R9 output not yet updated", 32'(mix_out1), 32'h7FFFFF);
        @(negedge clk);
        smp_valid = 1'b0;
        check("R9 valid pulse", 32'(mix_valid), 1);
        check("R9 updated one cycle later", 32'(mix_out1), 32'd300);
        smp_bus[0*W +: W] = 24'd999;
        @(negedge clk);
        check("R9 valid drops", 32'(mix_valid), 0);
        @(negedge clk);
        check("R9 hold without strobe", 32'(mix_out1), 32'd300);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule